// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Phase Generator

This block turns one fast system clock into two slow, non-overlapping phase levels for a synchronous model of a two-phase 4-bit processor system. The slow phases are not used as clocks. A free-running divider fixes the phase period, and each phase is high for a fixed window of divider counts. The first phase is high for roughly 30% of the period. The second phase has the same width and starts 16 input cycles after the first. Both levels come straight from flip-flops, so they cannot glitch.

Downstream logic runs on the system clock. It uses the outputs of this block as clock enables: a one-cycle strobe on the rising edge of each phase, the index of the current subcycle within the eight-subcycle instruction cycle, a one-hot decode of that index, and two address-capture qualifiers. One qualifier marks the second phase during the seventh subcycle, the other marks it during the eighth.

Top module: `twophase_clkgen`

## Requirements
- R1: While `rst_n` is low, `clk1`, `clk2`, `clk1_rise`, `clk2_rise`, `x22` and `x32` are 0, `subcycle` is 0 and `sub_flags` is 8'h01.
- R2: `clk1` is 1 in the first cycle after the first rising clock edge that sees `rst_n` high.
- R3: Both `clk1` and `clk2` repeat with a period of 27 input clock cycles.
- R4: `clk1` stays high for exactly 8 consecutive cycles in every period.
- R5: `clk2` stays high for exactly 8 consecutive cycles and rises exactly 16 cycles after `clk1` rises.
- R6: `clk1` and `clk2` are never high in the same cycle.
- R7: `clk1_rise` (and `clk2_rise`) is high for exactly one cycle, the first cycle in which `clk1` (and `clk2`) is high.
- R8: `subcycle` steps through the encoding A1=0, A2=1, A3=2, M1=3, M2=4, X1=5, X2=6, X3=7. It advances by one every 27 cycles, wraps from 7 to 0, and changes only in a cycle where both phases are low. It first changes 27 cycles after reset release.
- R9: `x22` is high exactly when `clk2` is high and `subcycle` is 6. `x32` is high exactly when `clk2` is high and `subcycle` is 7.
- R10: `sub_flags` is one-hot, and bit i is set exactly when `subcycle` equals i.
- R11: Asserting `rst_n` low in the middle of a run returns every output to its R1 value. Releasing it again restarts the sequence as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| clk1 | output | 1 | First phase level |
| clk2 | output | 1 | Second phase level |
| clk1_rise | output | 1 | One-cycle strobe at the start of the first phase |
| clk2_rise | output | 1 | One-cycle strobe at the start of the second phase |
| subcycle | output | 3 | Current subcycle index, 0 to 7 |
| sub_flags | output | 8 | One-hot decode of the subcycle index |
| x22 | output | 1 | Second phase during subcycle 6 |
| x32 | output | 1 | Second phase during subcycle 7 |

## Verification
Every output is one register after the divider count. Take k as the number of rising edges since reset release. After edge k, the phase position is (k-1) mod 27, which makes `clk1` high at k=1. The subcycle is floor(k/27) mod 8, so it steps on the edge where the count wraps, one cycle before the next `clk1` rise. The bench keeps its own edge counter k and samples every output on the falling edge that follows each rising edge. It compares each output against these formulas. Separate scenarios measure widths, period and offset directly from the observed edges, force the 7-to-0 wrap, and apply a reset in the middle of a phase window.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // Subcycle labels of one instruction cycle, in execution order.
  typedef enum logic [2:0] {
    SC_A1 = 3'd0,
    SC_A2 = 3'd1,
    SC_A3 = 3'd2,
    SC_M1 = 3'd3,
    SC_M2 = 3'd4,
    SC_X1 = 3'd5,
    SC_X2 = 3'd6,
    SC_X3 = 3'd7
  } subcycle_e;

  localparam int unsigned SUB_COUNT = 8;
  localparam int unsigned SUB_W     = 3;

endpackage

// File: rtl/tpc_divider.sv
module tpc_divider #(
  parameter int unsigned PERIOD = 27,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_d;

  // terminal count of the free-running divider
  assign wrap = (cnt == LAST);

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/tpc_phase.sv
module tpc_phase #(
  parameter int unsigned CW    = 5,
  parameter int unsigned START = 0,
  parameter int unsigned WIDTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  output logic          in_win,
  output logic          level,
  output logic          rise
);

  localparam logic [CW-1:0] FIRST = CW'(START);
  localparam logic [CW-1:0] LAST  = CW'(START + WIDTH - 1);

  logic level_d;
  logic rise_d;

  // a window starting at count zero needs no lower bound compare
  generate
    if (START == 0) begin : g_base
      assign in_win = (cnt <= LAST);
    end else begin : g_off
      assign in_win = (cnt >= FIRST) && (cnt <= LAST);
    end
  endgenerate

  always_comb begin
    level_d = in_win;
    rise_d  = (cnt == FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      rise  <= 1'b0;
    end else begin
      level <= level_d;
      rise  <= rise_d;
    end
  end

endmodule

// File: rtl/tpc_subcycle.sv
module tpc_subcycle
  import tpc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  output subcycle_e            idx,
  output logic [SUB_COUNT-1:0] flags
);

  subcycle_e idx_d;

  always_comb begin
    if (adv) idx_d = subcycle_e'(idx + 3'd1);
    else     idx_d = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= SC_A1;
    else        idx <= idx_d;
  end

  // one-hot decode, one comparator per subcycle
  generate
    for (genvar i = 0; i < SUB_COUNT; i++) begin : g_dec
      assign flags[i] = (idx == subcycle_e'(i));
    end
  endgenerate

endmodule

// File: rtl/tpc_qual.sv
module tpc_qual
  import tpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      win2,
  input  subcycle_e idx,
  output logic      x22,
  output logic      x32
);

  logic x22_d;
  logic x32_d;

  // the subcycle is steady across the whole second-phase window
  always_comb begin
    x22_d = win2 && (idx == SC_X2);
    x32_d = win2 && (idx == SC_X3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x22 <= 1'b0;
      x32 <= 1'b0;
    end else begin
      x22 <= x22_d;
      x32 <= x32_d;
    end
  end

endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
  parameter int unsigned DIV_PERIOD = 27,
  parameter int unsigned PH1_START  = 0,
  parameter int unsigned PH1_WIDTH  = 8,
  parameter int unsigned PH2_START  = 16,
  parameter int unsigned PH2_WIDTH  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       clk1,
  output logic       clk2,
  output logic       clk1_rise,
  output logic       clk2_rise,
  output logic [2:0] subcycle,
  output logic [7:0] sub_flags,
  output logic       x22,
  output logic       x32
);

  import tpc_pkg::*;

  localparam int unsigned CW = $clog2(DIV_PERIOD);

  logic [CW-1:0] cnt;
  logic          wrap;
  logic          win1;
  logic          win2;
  subcycle_e     sc;

  tpc_divider #(.PERIOD(DIV_PERIOD), .CW(CW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  tpc_phase #(.CW(CW), .START(PH1_START), .WIDTH(PH1_WIDTH)) u_ph1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .in_win (win1),
    .level  (clk1),
    .rise   (clk1_rise)
  );

  tpc_phase #(.CW(CW), .START(PH2_START), .WIDTH(PH2_WIDTH)) u_ph2 (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .in_win (win2),
    .level  (clk2),
    .rise   (clk2_rise)
  );

  tpc_subcycle u_sub (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (wrap),
    .idx   (sc),
    .flags (sub_flags)
  );

  tpc_qual u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .win2  (win2),
    .idx   (sc),
    .x22   (x22),
    .x32   (x32)
  );

  assign subcycle = sc;

  // first-phase window is only used through its registered level
  logic unused_win1;
  assign unused_win1 = win1;

endmodule

// File: rtl/tpc_chk.sv
module tpc_chk #(
  parameter int unsigned PERIOD = 27,
  parameter int unsigned W1     = 8,
  parameter int unsigned W2     = 8,
  parameter int unsigned OFFSET = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk1,
  input logic       clk2,
  input logic       clk1_rise,
  input logic       clk2_rise,
  input logic [2:0] subcycle,
  input logic [7:0] sub_flags,
  input logic       x22,
  input logic       x32
);

  logic [15:0] hi1_len;
  logic [15:0] hi2_len;
  logic [15:0] since1;
  logic        seen1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi1_len <= '0;
      hi2_len <= '0;
      since1  <= '0;
      seen1   <= 1'b0;
    end else begin
      hi1_len <= clk1 ? hi1_len + 16'd1 : 16'd0;
      hi2_len <= clk2 ? hi2_len + 16'd1 : 16'd0;
      since1  <= clk1_rise ? 16'd1 : since1 + 16'd1;
      if (clk1_rise) seen1 <= 1'b1;
    end
  end

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk1 && clk2));

  // R7
  rise1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk1_rise |-> (clk1 && !$past(clk1)));

  // R7
  rise2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk2_rise |-> (clk2 && !$past(clk2)));

  // R4
  clk1_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk1) |-> (hi1_len == 16'(W1)));

  // R5
  clk2_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk2) |-> (hi2_len == 16'(W2)));

  // R5
  phase_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk2_rise && seen1) |-> (since1 == 16'(OFFSET)));

  // R3
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk1_rise && seen1) |-> (since1 == 16'(PERIOD)));

  // R8
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (subcycle != $past(subcycle)) |->
      ((subcycle == 3'($past(subcycle) + 3'd1)) && !clk1 && !clk2));

  // R9
  x22_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x22 == (clk2 && (subcycle == 3'd6)));

  // R9
  x32_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x32 == (clk2 && (subcycle == 3'd7)));

  // R10
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sub_flags) == 1) && sub_flags[subcycle]);

endmodule

bind twophase_clkgen tpc_chk #(
  .PERIOD (DIV_PERIOD),
  .W1     (PH1_WIDTH),
  .W2     (PH2_WIDTH),
  .OFFSET (PH2_START - PH1_START)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk1      (clk1),
  .clk2      (clk2),
  .clk1_rise (clk1_rise),
  .clk2_rise (clk2_rise),
  .subcycle  (subcycle),
  .sub_flags (sub_flags),
  .x22       (x22),
  .x32       (x32)
);

// File: tb/sim_twophase_clkgen.sv
`timescale 1ns/1ps
module sim_twophase_clkgen;

  localparam int PER = 27;

  logic       clk;
  logic       rst_n;
  logic       clk1, clk2, clk1_rise, clk2_rise, x22, x32;
  logic [2:0] subcycle;
  logic [7:0] sub_flags;

  int checks = 0;
  int fails  = 0;
  int k      = 0;   // rising edges since reset release
  bit done   = 0;

  twophase_clkgen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk1      (clk1),
    .clk2      (clk2),
    .clk1_rise (clk1_rise),
    .clk2_rise (clk2_rise),
    .subcycle  (subcycle),
    .sub_flags (sub_flags),
    .x22       (x22),
    .x32       (x32)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (k=%0d)", req, act, exp, k);
    end
  endtask

  task automatic step();
    @(posedge clk);
    k++;
    @(negedge clk);
  endtask

  // compare all outputs with the value due after edge k
  task automatic cmp_model();
    int ph, sc;
    ph = (k - 1) % PER;
    sc = (k / PER) % 8;
    chk(clk1 == (ph < 8), "R4 clk1 level", clk1, ph < 8);
    chk(clk2 == (ph >= 16 && ph < 24), "R5 clk2 level", clk2, ph >= 16 && ph < 24);
    chk(clk1_rise == (ph == 0), "R7 clk1_rise", clk1_rise, ph == 0);
    chk(clk2_rise == (ph == 16), "R7 clk2_rise", clk2_rise, ph == 16);
    chk(subcycle == 3'(sc), "R8 subcycle", subcycle, sc);
    chk(sub_flags == 8'(1 << sc), "R10 sub_flags", sub_flags, 1 << sc);
    chk(x22 == (clk2 && sc == 6), "R9 x22", x22, clk2 && sc == 6);
    chk(x32 == (clk2 && sc == 7), "R9 x32", x32, clk2 && sc == 7);
    chk(!(clk1 && clk2), "R6 overlap", {clk1, clk2}, 0);
  endtask

  task automatic check_reset_state(input string req);
    chk({clk1, clk2, clk1_rise, clk2_rise, x22, x32} == 6'd0, req,
        {clk1, clk2, clk1_rise, clk2_rise, x22, x32}, 0);
    chk(subcycle == 3'd0, req, subcycle, 0);
    chk(sub_flags == 8'h01, req, sub_flags, 8'h01);
  endtask

  // R1: outputs held at reset values
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_reset_state("R1 reset state");
    end
  endtask

  // R2: first phase high right after release
  task automatic t_release();
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    step();
    chk(clk1 == 1'b1, "R2 clk1 after release", clk1, 1);
    chk(clk1_rise == 1'b1, "R2 clk1_rise after release", clk1_rise, 1);
    cmp_model();
  endtask

  // R4 R5 R6 R7 R8 R9 R10: full comparison over n edges
  task automatic t_stream(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      cmp_model();
    end
  endtask

  // R3 R4 R5: measure edges directly
  task automatic t_measure();
    int r1a, r1b, r2, w1, w2;
    bit p1, p2;
    r1a = -1; r1b = -1; r2 = -1; w1 = 0; w2 = 0;
    p1 = clk1; p2 = clk2;
    for (int i = 0; i < 3 * PER; i++) begin
      step();
      if (clk1 && !p1) begin
        if (r1a < 0) r1a = k; else if (r1b < 0) r1b = k;
      end
      if (clk2 && !p2 && r1a >= 0 && r2 < 0) r2 = k;
      if (r1a >= 0 && r1b < 0 && clk1) w1++;
      if (r2 >= 0 && r1b < 0 && clk2) w2++;
      p1 = clk1; p2 = clk2;
    end
    chk(r1b - r1a == PER, "R3 clk1 period", r1b - r1a, PER);
    chk(w1 == 8, "R4 clk1 width", w1, 8);
    chk(w2 == 8, "R5 clk2 width", w2, 8);
    chk(r2 - r1a == 16, "R5 clk2 offset", r2 - r1a, 16);
  endtask

  // R8: wrap from X3 back to A1
  task automatic t_wrap();
    while (subcycle != 3'd7) step();
    while (subcycle == 3'd7) begin
      step();
      cmp_model();
    end
    chk(subcycle == 3'd0, "R8 wrap to A1", subcycle, 0);
    chk(!clk1 && !clk2, "R8 wrap with phases low", {clk1, clk2}, 0);
  endtask

  // R11: reset in the middle of the second phase
  task automatic t_midreset();
    while (!clk2) step();
    step();
    rst_n = 1'b0;
    #1;
    check_reset_state("R11 async reset");
    @(negedge clk);
    check_reset_state("R11 reset hold");
    t_release();
    t_stream(PER + 5);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_release();
    t_stream(8 * PER * 2 + 30);
    t_measure();
    t_wrap();
    t_midreset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule